// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers edge-signalled requests from a set of device sources and one unmaskable source. It raises a single request line toward the processor. Each device source has its own priority field and mask bit, and its pending latch sets on a rising edge of its input. While no interrupt is in service, a pending, unmasked source raises the processor request. Once a handler is running, a source raises the request only if its level is strictly above the level now in service.

When the processor acknowledges, the controller picks the best eligible source and returns its 8-bit vector together with a one-cycle valid strobe. It clears that source's pending latch and pushes the source's level onto an in-service stack. A later request of higher level can then nest above the running handler. An end-of-interrupt pulse pops the stack, and the level beneath becomes current again. If an acknowledge finds nothing eligible and nothing becomes eligible within a fixed number of cycles, the controller answers with a one-cycle bus-error strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, `cpu_req`, `vec_valid` and `bus_err` are low and `cur_level` is 0, meaning nothing is in service.
- R2: A rising edge on `irq_in[i]` sets that source's pending latch at the clock edge where it is first sampled high. From then on, `cpu_req` is high if the source is eligible.
- R3: Device source i has level `cfg_prio[i*PRIO_W +: PRIO_W] + 1`. The winner is the eligible source with the highest level. On equal levels, the lowest index wins.
- R4: When `cpu_ack` is sampled high while the controller is idle and a source is eligible, `vec_valid` pulses for one cycle after that edge. At the same time, `vec_out` = `cfg_vbase + i` (modulo 256), and the winner's pending latch is cleared.
- R5: A device source whose `cfg_mask` bit is 1 is never chosen and does not raise `cpu_req`. It stays pending and is taken once the bit returns to 0.
- R6: A pending source whose level is not above `cur_level` does not raise `cpu_req`. It stays pending until an end-of-interrupt lowers `cur_level` below its level.
- R7: A delivery pushes the winner's level, and `cur_level` shows it from the next cycle. A higher-level request is taken while a lower one is in service. Each `eoi` pulse restores the previous level.
- R8: The unmaskable source (rising edge on `nmi_in`) has level 2^PRIO_W + 1, which is above every device. `cfg_mask` does not affect it, and its vector is the parameter `NMI_VEC`. It does not nest over itself.
- R9: If an acknowledge finds nothing eligible, the controller waits. If a source becomes eligible within `TIMEOUT` cycles, its vector is delivered. Otherwise `bus_err` pulses for one cycle `TIMEOUT` clock edges after the acknowledge edge, and no vector is delivered.
- R10: An `eoi` pulse while nothing is in service has no effect: `cur_level` stays 0.
- R11: An input held high produces exactly one delivery. No new request appears until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Device request inputs, rising-edge sensitive |
| nmi_in | input | 1 | Unmaskable request input, rising-edge sensitive |
| cfg_prio | input | NSRC*PRIO_W | Per-source priority fields, source i at bits i*PRIO_W |
| cfg_mask | input | NSRC | Per-source mask, 1 blocks the source |
| cfg_vbase | input | 8 | Base added to the source index to form a vector |
| cpu_req | output | 1 | Request toward the processor |
| cpu_ack | input | 1 | Processor acknowledge |
| vec_valid | output | 1 | One-cycle strobe, vector valid |
| vec_out | output | 8 | Delivered vector |
| bus_err | output | 1 | One-cycle strobe, no vector produced within the timeout |
| eoi | input | 1 | End-of-interrupt pulse, pops the in-service stack |
| cur_level | output | 8 | Level currently in service, 0 when idle |

## Verification
The bench raises several equal-level sources in the same cycle. A design that compares with the wrong sense would deliver the higher index first, and the scoreboard would see the vectors in the wrong order. It also nests a high-level source over a lower one and stacks the unmaskable source twice. A flat in-service register instead of a stack would fail here, because it would return to level 0 after the first end-of-interrupt. The acknowledge timeout is counted to the exact cycle, and it is also cancelled midway by unmasking a source, which catches an off-by-one counter or a wait state that never delivers. Finally, an input is held high after delivery, which exposes a level-sensitive latch that would request a second time.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef logic [7:0] ivc_lvl_t;

    typedef enum logic {
        IVC_IDLE = 1'b0,
        IVC_WAIT = 1'b1
    } ivc_state_e;

    typedef struct packed {
        logic     hit;
        logic     nmi;
        logic [7:0] idx;
        ivc_lvl_t lvl;
    } ivc_pick_t;

    function automatic ivc_lvl_t nmi_level(input int prio_w);
        return ivc_lvl_t'((1 << prio_w) + 1);
    endfunction

endpackage

// File: rtl/ivc_pend.sv
module ivc_pend #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            nmi_in,
    input  logic [NSRC-1:0] clr_src,
    input  logic            clr_nmi,
    output logic [NSRC-1:0] pend,
    output logic            nmi_pend
);
    logic [NSRC-1:0] irq_q;
    logic            nmi_q;
    logic [NSRC-1:0] rise;
    logic            nmi_rise;

    assign rise     = irq_in & ~irq_q;
    assign nmi_rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= '0;
            nmi_q    <= 1'b0;
            pend     <= '0;
            nmi_pend <= 1'b0;
        end else begin
            irq_q    <= irq_in;
            nmi_q    <= nmi_in;
            pend     <= (pend & ~clr_src) | rise;
            nmi_pend <= (nmi_pend & ~clr_nmi) | nmi_rise;
        end
    end

    // R11: a cleared latch only comes back on a fresh rising edge
    assert_no_reset_without_edge_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_nmi) && !$past(nmi_rise)) |-> !nmi_pend);
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb
    import ivc_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC-1:0]        pend,
    input  logic                   nmi_pend,
    input  logic [NSRC*PRIO_W-1:0] cfg_prio,
    input  logic [NSRC-1:0]        cfg_mask,
    input  ivc_lvl_t               cur_lvl,
    output ivc_pick_t              pick
);
    localparam ivc_lvl_t NMI_LVL = nmi_level(PRIO_W);

    always_comb begin
        ivc_lvl_t lvl_i;
        pick = '0;
        // descending scan with >= leaves the lowest index on ties
        for (int i = NSRC - 1; i >= 0; i--) begin
            lvl_i = ivc_lvl_t'(cfg_prio[i*PRIO_W +: PRIO_W]) + 8'd1;
            if (pend[i] && !cfg_mask[i] && lvl_i > cur_lvl && lvl_i >= pick.lvl) begin
                pick.hit = 1'b1;
                pick.idx = 8'(i);
                pick.lvl = lvl_i;
            end
        end
        if (nmi_pend && NMI_LVL > cur_lvl) begin
            pick.hit = 1'b1;
            pick.nmi = 1'b1;
            pick.idx = '0;
            pick.lvl = NMI_LVL;
        end
    end
endmodule

// File: rtl/ivc_stack.sv
module ivc_stack
    import ivc_pkg::*;
#(
    parameter int DEPTH = 9
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  logic     pop,
    input  ivc_lvl_t lvl_in,
    output ivc_lvl_t top_lvl
);
    localparam int SPW = $clog2(DEPTH + 1);

    ivc_lvl_t       stk [DEPTH];
    logic [SPW-1:0] sp;
    logic           do_pop;

    assign do_pop  = pop && (sp != '0);
    assign top_lvl = (sp == '0) ? '0 : stk[sp - SPW'(1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push && do_pop) begin
            stk[sp - SPW'(1)] <= lvl_in;
        end else if (push && sp != SPW'(DEPTH)) begin
            stk[sp] <= lvl_in;
            sp      <= sp + SPW'(1);
        end else if (do_pop) begin
            sp <= sp - SPW'(1);
        end
    end

    // R7: nesting only ever pushes a strictly higher level
    assert_push_higher_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && sp != '0) |-> lvl_in > top_lvl);
    // R10: pointer stays inside the storage
    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        sp <= SPW'(DEPTH));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int         NSRC    = 8,
    parameter int         PRIO_W  = 3,
    parameter int         TIMEOUT = 16,
    parameter logic [7:0] NMI_VEC = 8'h02
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        irq_in,
    input  logic                   nmi_in,
    input  logic [NSRC*PRIO_W-1:0] cfg_prio,
    input  logic [NSRC-1:0]        cfg_mask,
    input  logic [7:0]             cfg_vbase,
    output logic                   cpu_req,
    input  logic                   cpu_ack,
    output logic                   vec_valid,
    output logic [7:0]             vec_out,
    output logic                   bus_err,
    input  logic                   eoi,
    output logic [7:0]             cur_level
);
    localparam int       DEPTH   = NSRC + 1;
    localparam int       CW      = $clog2(TIMEOUT + 1);
    localparam ivc_lvl_t NMI_LVL = nmi_level(PRIO_W);

    ivc_state_e      st;
    logic [CW-1:0]   cnt;
    logic [NSRC-1:0] pend;
    logic            nmi_pend;
    logic [NSRC-1:0] clr_src;
    logic            deliver;
    ivc_pick_t       pick;
    ivc_lvl_t        cur_lvl;

    assign cur_level = cur_lvl;
    assign cpu_req   = (st == IVC_IDLE) && pick.hit;
    assign deliver   = pick.hit && ((st == IVC_IDLE && cpu_ack) || st == IVC_WAIT);

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            clr_src[i] = deliver && !pick.nmi && (pick.idx == 8'(i));
    end

    ivc_pend #(.NSRC(NSRC)) pend_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in),
        .clr_src(clr_src), .clr_nmi(deliver && pick.nmi),
        .pend(pend), .nmi_pend(nmi_pend)
    );

    ivc_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) arb_i (
        .pend(pend), .nmi_pend(nmi_pend), .cfg_prio(cfg_prio),
        .cfg_mask(cfg_mask), .cur_lvl(cur_lvl), .pick(pick)
    );

    ivc_stack #(.DEPTH(DEPTH)) stack_i (
        .clk(clk), .rst(rst), .push(deliver), .pop(eoi),
        .lvl_in(pick.lvl), .top_lvl(cur_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= IVC_IDLE;
            cnt       <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
            bus_err   <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            bus_err   <= 1'b0;
            if (deliver) begin
                vec_valid <= 1'b1;
                vec_out   <= pick.nmi ? NMI_VEC : cfg_vbase + pick.idx;
                st        <= IVC_IDLE;
                cnt       <= '0;
            end else if (st == IVC_IDLE && cpu_ack) begin
                st  <= IVC_WAIT;
                cnt <= '0;
            end else if (st == IVC_WAIT) begin
                if (cnt == CW'(TIMEOUT - 1)) begin
                    bus_err <= 1'b1;
                    st      <= IVC_IDLE;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R9: a vector and a bus error never answer the same acknowledge
    assert_vec_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(vec_valid && bus_err));
    // R9: wait counter never passes the timeout
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(TIMEOUT));
    // R6: request only for a level above the one in service
    assert_req_above_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> pick.lvl > cur_lvl);
    // R7: after a delivery without eoi the stack top is the delivered level
    assert_level_pushed_R7: assert property (@(posedge clk) disable iff (rst)
        (deliver && !eoi) |=> cur_lvl == $past(pick.lvl));
    // R8: unmaskable source above current level is always offered or being fetched
    assert_nmi_offered_R8: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && cur_lvl < NMI_LVL) |-> (cpu_req || st == IVC_WAIT));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int PW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0]    irq_in = '0;
    logic               nmi_in = 1'b0;
    logic [NSRC*PW-1:0] cfg_prio = '0;
    logic [NSRC-1:0]    cfg_mask = '0;
    logic [7:0]         cfg_vbase = 8'h40;
    logic               cpu_req, cpu_ack = 1'b0;
    logic               vec_valid, bus_err;
    logic [7:0]         vec_out, cur_level;
    logic               eoi = 1'b0;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in),
        .cfg_prio(cfg_prio), .cfg_mask(cfg_mask), .cfg_vbase(cfg_vbase),
        .cpu_req(cpu_req), .cpu_ack(cpu_ack), .vec_valid(vec_valid),
        .vec_out(vec_out), .bus_err(bus_err), .eoi(eoi), .cur_level(cur_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [NSRC-1:0] bits);
        @(negedge clk) irq_in = irq_in | bits;
        @(negedge clk) irq_in = irq_in & ~bits;
    endtask

    task automatic pulse_nmi();
        @(negedge clk) nmi_in = 1'b1;
        @(negedge clk) nmi_in = 1'b0;
    endtask

    task automatic ack(input logic [7:0] expv);
        exp_q.push_back(expv);
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
    endtask

    task automatic end_irq();
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
    endtask

    // monitor: compare every delivered vector against the scoreboard (R4)
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) chk("R4 unexpected vector", {24'h0, vec_out}, 32'hFFFF);
            else chk("R4 vector", {24'h0, vec_out}, {24'h0, exp_q.pop_front()});
        end
    end

    initial begin
        #(8 * 100000);
        nfail++; nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        cfg_prio[0 +: 3] = 3'd2;
        cfg_prio[3 +: 3] = 3'd5;
        cfg_prio[6 +: 3] = 3'd5;
        cfg_prio[9 +: 3] = 3'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req", cpu_req, 0);
        chk("R1 valid", vec_valid, 0);
        chk("R1 err", bus_err, 0);
        chk("R1 level", cur_level, 0);

        // R2 / R4 single source
        pulse(8'h08);
        chk("R2 req", cpu_req, 1);
        ack(8'h43);
        chk("R7 level", cur_level, 2);
        end_irq();
        chk("R7 back to idle", cur_level, 0);
        chk("R4 latch cleared", cpu_req, 0);

        // R3 ties and highest level; R6 blocked by equal level
        pulse(8'h07);
        ack(8'h41);
        chk("R3 level", cur_level, 6);
        chk("R6 equal level blocked", cpu_req, 0);
        end_irq();
        chk("R6 pending after eoi", cpu_req, 1);
        ack(8'h42);
        end_irq();
        ack(8'h40);
        chk("R3 last", cur_level, 3);
        end_irq();

        // R7 nesting
        pulse(8'h08);
        ack(8'h43);
        pulse(8'h02);
        chk("R7 nest req", cpu_req, 1);
        ack(8'h41);
        chk("R7 nested level", cur_level, 6);
        end_irq();
        chk("R7 restored", cur_level, 2);
        end_irq();
        chk("R7 idle", cur_level, 0);

        // R5 mask + R9 timeout
        cfg_mask = 8'h01;
        pulse(8'h01);
        chk("R5 masked no req", cpu_req, 0);
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            if (n == 15) chk("R9 no early err", bus_err, 0);
            if (n == 16) chk("R9 err at timeout", bus_err, 1);
        end
        @(negedge clk);
        chk("R9 err one cycle", bus_err, 0);
        // R9 rescue: unmask during wait
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back(8'h40);
        cfg_mask = 8'h00;
        @(negedge clk);
        chk("R5 taken after unmask", cur_level, 3);
        end_irq();

        // R8 unmaskable source
        pulse(8'h02);
        ack(8'h41);
        cfg_mask = 8'hFF;
        pulse_nmi();
        chk("R8 req while masked", cpu_req, 1);
        ack(8'h02);
        chk("R8 level", cur_level, 9);
        pulse_nmi();
        chk("R8 no self nest", cpu_req, 0);
        end_irq();
        chk("R8 pending again", cpu_req, 1);
        ack(8'h02);
        end_irq();
        end_irq();
        chk("R8 unwound", cur_level, 0);
        cfg_mask = 8'h00;

        // R10 eoi on empty stack
        end_irq();
        chk("R10 level", cur_level, 0);
        chk("R10 req", cpu_req, 0);

        // R11 held input
        @(negedge clk) irq_in[3] = 1'b1;
        @(negedge clk);
        ack(8'h43);
        end_irq();
        repeat (2) @(negedge clk);
        chk("R11 held no rerequest", cpu_req, 0);
        irq_in[3] = 1'b0;

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule